// File: doc/BRIEF.md
# Watchdog and Alarm Down-Counter

This block is a 24-bit down-counter with a seed register and an alarm flag. In periodic mode it counts a slow tick (one per second) and raises the flag every time it reaches zero, reloading itself from the seed so that it keeps running. In watchdog mode it counts a fast tick (4096 per second), raises the flag once at zero and then stops. Software must touch the counter before it runs out. A watchdog expiry produces a fixed-length low pulse on either the reset request or the interrupt request, chosen by a steering bit. While the reset pulse is active, register access is blocked.

The counter is reached through a plain byte-wide register port (strobe, write enable, byte select, data). It is not a stream, so it has no valid/ready handshake: an access is accepted in the cycle its strobe is high unless access is blocked. Control bits and the status-flag write are level or strobe pins. Every access to a counter byte while the block is enabled reloads the live count from the seed. With the enable bit low, the three bytes are plain storage. The pulse length is `PULSE_TICKS` fast ticks; the default of 1024 gives a quarter second.

Top module: `wdg_alarm_counter`

## Requirements
- R1: A write to counter byte k (select 0 = bits 7:0, 1 = bits 15:8, 2 = bits 23:16; select 3 is ignored) loads byte k of both the seed and the live count. A read returns the live count byte in the same cycle.
- R2: With `ctl_enable` = 0 neither tick changes the count, and reads have no side effect.
- R3: In periodic mode (`ctl_mode` = 0) only `tick_sec` decrements the count. The tick that takes it to zero sets `alarm_flag` and reloads the seed.
- R4: In watchdog mode (`ctl_mode` = 1) only `tick_fast` decrements the count. The tick that takes it to zero sets `alarm_flag`, and the count then stays at 0.
- R5: While enabled, any accepted read or write of a counter byte reloads the live count from the seed.
- R6: If all 24 seed bits are zero while enabled, the counter never runs and `alarm_flag` is never set.
- R7: In watchdog mode with `ctl_steer` = 0, the cycle after the flag is set `rst_req_n` goes low and `access_block` goes high for exactly `PULSE_TICKS` fast ticks. Accesses are ignored during the pulse, and `alarm_flag` clears when the pulse ends.
- R8: In watchdog mode with `ctl_steer` = 1 and `ctl_irq_en` = 1, `irq_n` pulses low for exactly `PULSE_TICKS` fast ticks. Clearing the flag or the interrupt enable during the pulse does not shorten it, and `alarm_flag` clears at its end.
- R9: A counter write during an interrupt pulse takes effect, but the count does not decrement until the pulse has ended.
- R10: In periodic mode with `ctl_irq_en` = 1, `irq_n` is low exactly while `alarm_flag` is 1. The flag clears only when `flag_we` is pulsed with `flag_wdata` = 0; writing 1 leaves it unchanged.
- R11: If `alarm_flag` is already 1 when `ctl_mode` becomes 1, the steered pulse starts on the next clock edge.
- R12: After reset the count and seed are 0, `alarm_flag` is 0, `irq_n` and `rst_req_n` are 1, and `access_block` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle strobe, slow time base |
| tick_fast | input | 1 | One-cycle strobe, fast time base |
| ctl_enable | input | 1 | 1 = counter runs, 0 = bytes are storage |
| ctl_mode | input | 1 | 0 = periodic alarm, 1 = watchdog |
| ctl_steer | input | 1 | Watchdog pulse target: 0 = reset, 1 = interrupt |
| ctl_irq_en | input | 1 | Interrupt enable |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Counter byte select |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data (live count byte) |
| flag_we | input | 1 | Status flag write strobe |
| flag_wdata | input | 1 | Value written to the flag (only 0 acts) |
| irq_n | output | 1 | Active-low interrupt request |
| rst_req_n | output | 1 | Active-low reset pulse request |
| access_block | output | 1 | High while register access is inhibited |
| alarm_flag | output | 1 | Alarm flag |

## Verification
The bench targets the corner cases that are easy to get wrong.

- **Pulse length.** It counts fast ticks through the pulse and samples one tick before the end and at the end. A timer that is off by one, or that stops when the flag or the interrupt enable is cleared, ends the pulse early and fails here.
- **Reload on read.** It reads twice around a single slow tick. A design that reloads only on writes returns a count one lower on the second read.
- **Writes during a pulse.** It writes a blocked byte during a reset pulse and a live byte during an interrupt pulse. A design that lets the blocked write through, or that keeps decrementing during the pulse, reads back the wrong count afterwards.
- **Flag handling.** It checks that writing 1 to the flag does nothing, that an all-zero seed never raises the flag, and that a flag already set starts a pulse as soon as watchdog mode is selected.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_PERIODIC = 1'b0,
    MODE_WATCHDOG = 1'b1
  } wdg_mode_e;
endpackage

// File: rtl/wdg_pulse_timer.sv
module wdg_pulse_timer #(
  parameter int unsigned PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(PULSE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  logic [CW-1:0] ticks_seen;

  assign done = active && tick && (ticks_seen == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      ticks_seen <= '0;
    end else if (!active) begin
      if (start) begin
        active     <= 1'b1;
        ticks_seen <= '0;
      end
    end else if (done) begin
      active     <= 1'b0;
      ticks_seen <= '0;
    end else if (tick) begin
      ticks_seen <= ticks_seen + 1'b1;
    end
  end

  // R8: once running, the pulse holds until a tick arrives
  p_no_truncate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> active);

  // R7: the end strobe only exists inside a pulse, and the pulse then drops
  p_pulse_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              enable,
  input  logic                              mode_wd,
  input  logic                              decr,
  input  logic                              acc,
  input  logic                              we,
  input  logic [$clog2(CNT_W/wdg_pkg::BYTE_W)-1:0] sel,
  input  logic [wdg_pkg::BYTE_W-1:0]        wdata,
  output logic [wdg_pkg::BYTE_W-1:0]        rdata,
  output logic                              zero_hit
);
  import wdg_pkg::*;
  localparam int unsigned NBYTES = CNT_W / BYTE_W;
  localparam int unsigned SEL_W  = $clog2(NBYTES);

  logic [CNT_W-1:0] count, seed, seed_next;
  logic             armed;
  logic             run;

  always_comb begin
    seed_next = seed;
    rdata     = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (sel == SEL_W'(b)) begin
        rdata = count[b*BYTE_W +: BYTE_W];
        if (we) seed_next[b*BYTE_W +: BYTE_W] = wdata;
      end
    end
  end

  assign run      = enable && armed;
  assign zero_hit = run && decr && !acc && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      seed  <= '0;
      armed <= 1'b0;
    end else if (acc && we) begin
      seed  <= seed_next;
      count <= seed_next;
      armed <= (seed_next != '0);
    end else if (acc && enable) begin
      count <= seed;
      armed <= (seed != '0);
    end else if (zero_hit) begin
      if (mode_wd) begin
        count <= '0;
        armed <= 1'b0;
      end else begin
        count <= seed;
      end
    end else if (run && decr) begin
      count <= count - 1'b1;
    end
  end

  // R1: a write leaves live count equal to the seed
  p_write_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && we) |=> (count == seed));

  // R2: disabled and untouched, the count holds
  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !acc) |=> $stable(count));

  // R4: watchdog expiry parks the count at zero
  p_wd_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && mode_wd) |=> (count == '0));

  // R5: an enabled read restores the seed
  p_read_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !we && enable) |=> (count == $past(seed)));
endmodule

// File: rtl/wdg_alarm_counter.sv
module wdg_alarm_counter #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned PULSE_TICKS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_sec,
  input  logic       tick_fast,
  input  logic       ctl_enable,
  input  logic       ctl_mode,
  input  logic       ctl_steer,
  input  logic       ctl_irq_en,
  input  logic       acc_en,
  input  logic       acc_we,
  input  logic [$clog2(CNT_W/8)-1:0] acc_sel,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       flag_we,
  input  logic       flag_wdata,
  output logic       irq_n,
  output logic       rst_req_n,
  output logic       access_block,
  output logic       alarm_flag
);
  import wdg_pkg::*;
  localparam int unsigned NBYTES = CNT_W / BYTE_W;
  localparam int unsigned SEL_W  = $clog2(NBYTES);

  wdg_mode_e mode;
  logic      acc_ok, decr, zero_hit;
  logic      pulse_act, pulse_done, pulse_start, to_irq;

  assign mode   = wdg_mode_e'(ctl_mode);
  assign acc_ok = acc_en && !access_block && (acc_sel < SEL_W'(NBYTES));
  assign decr   = ((mode == MODE_WATCHDOG) ? tick_fast : tick_sec) && !pulse_act;

  wdg_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctl_enable),
    .mode_wd  (mode == MODE_WATCHDOG),
    .decr     (decr),
    .acc      (acc_ok),
    .we       (acc_we),
    .sel      (acc_sel),
    .wdata    (acc_wdata),
    .rdata    (acc_rdata),
    .zero_hit (zero_hit)
  );

  assign pulse_start = (mode == MODE_WATCHDOG) && alarm_flag && !pulse_act
                       && (!ctl_steer || ctl_irq_en);

  wdg_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (pulse_start),
    .tick   (tick_fast),
    .active (pulse_act),
    .done   (pulse_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      to_irq     <= 1'b0;
    end else begin
      if (pulse_start) to_irq <= ctl_steer;
      if (zero_hit)
        alarm_flag <= 1'b1;
      else if (pulse_done)
        alarm_flag <= 1'b0;
      else if (flag_we && !flag_wdata && !pulse_act)
        alarm_flag <= 1'b0;
    end
  end

  assign access_block = pulse_act && !to_irq;
  assign rst_req_n    = !(pulse_act && !to_irq);
  assign irq_n        = !((pulse_act && to_irq) ||
                          ((mode == MODE_PERIODIC) && ctl_irq_en && alarm_flag));

  // R10: outside a pulse the flag only falls on an explicit zero write
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !pulse_act && !(flag_we && !flag_wdata)) |=> alarm_flag);

  // R7: the flag stays set through a pulse until its end strobe
  p_flag_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_act && !pulse_done) |=> alarm_flag);

  // R9: no decrement reaches the core while a pulse runs
  p_no_run_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_act |-> !zero_hit);

  // R11: a set flag under watchdog mode with a legal target starts a pulse
  p_immediate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> pulse_act);
endmodule

// File: tb/wdg_alarm_counter_bench.sv
module wdg_alarm_counter_bench;
  localparam int unsigned PT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_sec = 0, tick_fast = 0;
  logic ctl_enable = 0, ctl_mode = 0, ctl_steer = 0, ctl_irq_en = 0;
  logic acc_en = 0, acc_we = 0;
  logic [1:0] acc_sel = 0;
  logic [7:0] acc_wdata = 0, acc_rdata;
  logic flag_we = 0, flag_wdata = 0;
  logic irq_n, rst_req_n, access_block, alarm_flag;

  int n_checks = 0, n_fail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  wdg_alarm_counter #(.CNT_W(24), .PULSE_TICKS(PT)) u_wdg_alarm_counter (
    .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .tick_fast(tick_fast),
    .ctl_enable(ctl_enable), .ctl_mode(ctl_mode), .ctl_steer(ctl_steer),
    .ctl_irq_en(ctl_irq_en), .acc_en(acc_en), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_n(irq_n),
    .rst_req_n(rst_req_n), .access_block(access_block), .alarm_flag(alarm_flag)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    acc_en = 1; acc_we = 1; acc_sel = s; acc_wdata = d;
    step();
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    acc_en = 1; acc_we = 0; acc_sel = s;
    #1 d = acc_rdata;
    step();
    acc_en = 0;
  endtask

  task automatic sec_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_sec = 1; step(); tick_sec = 0; step();
    end
  endtask

  task automatic fast_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = 1; step(); tick_fast = 0; step();
    end
  endtask

  task automatic flag_write(input logic v);
    flag_we = 1; flag_wdata = v; step(); flag_we = 0;
  endtask

  task automatic t_reset();
    check(irq_n, 1, "R12 irq_n");
    check(rst_req_n, 1, "R12 rst_req_n");
    check(access_block, 0, "R12 access_block");
    check(alarm_flag, 0, "R12 alarm_flag");
    rd(2'd0, rv); check(rv, 0, "R12 count byte0");
  endtask

  task automatic t_storage();
    ctl_enable = 0;
    wr(2'd0, 8'h12); wr(2'd1, 8'h34); wr(2'd2, 8'h56);
    sec_ticks(3); fast_ticks(3);
    rd(2'd0, rv); check(rv, 'h12, "R1/R2 byte0");
    rd(2'd1, rv); check(rv, 'h34, "R1/R2 byte1");
    rd(2'd2, rv); check(rv, 'h56, "R1/R2 byte2");
    wr(2'd3, 8'hFF);
    rd(2'd0, rv); check(rv, 'h12, "R1 select 3 ignored");
    check(alarm_flag, 0, "R2 flag");
  endtask

  task automatic t_periodic();
    ctl_enable = 1; ctl_mode = 0; ctl_irq_en = 0;
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h03);
    fast_ticks(2);
    rd(2'd0, rv); check(rv, 3, "R3 fast tick ignored");
    sec_ticks(1);
    rd(2'd0, rv); check(rv, 2, "R3 one decrement");
    sec_ticks(1);
    rd(2'd0, rv); check(rv, 2, "R5 read reloaded seed");
    sec_ticks(3);
    check(alarm_flag, 1, "R3 flag at zero");
    check(irq_n, 1, "R10 irq masked");
    rd(2'd0, rv); check(rv, 3, "R3 reload after zero");
  endtask

  task automatic t_periodic_irq();
    ctl_irq_en = 1; step();
    check(irq_n, 0, "R10 irq follows flag");
    flag_write(1'b1);
    check(alarm_flag, 1, "R10 write 1 no effect");
    check(irq_n, 0, "R10 irq still low");
    flag_write(1'b0);
    check(alarm_flag, 0, "R10 write 0 clears");
    check(irq_n, 1, "R10 irq released");
  endtask

  task automatic t_zero_seed();
    ctl_irq_en = 0;
    wr(2'd0, 8'h00);
    sec_ticks(6);
    check(alarm_flag, 0, "R6 zero seed no flag");
    rd(2'd0, rv); check(rv, 0, "R6 count stays zero");
  endtask

  task automatic t_wd_reset();
    ctl_mode = 1; ctl_steer = 0; ctl_irq_en = 0;
    wr(2'd0, 8'h02);
    sec_ticks(3);
    check(alarm_flag, 0, "R4 slow tick ignored");
    fast_ticks(2);
    check(alarm_flag, 1, "R4 flag at zero");
    check(rst_req_n, 0, "R7 reset pulse low");
    check(access_block, 1, "R7 access blocked");
    check(irq_n, 1, "R7 irq untouched");
    wr(2'd0, 8'h77);
    fast_ticks(PT - 1);
    check(rst_req_n, 0, "R7 pulse not yet over");
    fast_ticks(1);
    check(rst_req_n, 1, "R7 pulse ended");
    check(access_block, 0, "R7 access restored");
    check(alarm_flag, 0, "R7 flag cleared");
    fast_ticks(2);
    rd(2'd0, rv); check(rv, 0, "R4/R7 stopped at zero, blocked write ignored");
  endtask

  task automatic t_wd_irq();
    ctl_steer = 1; ctl_irq_en = 1;
    wr(2'd0, 8'h01);
    fast_ticks(1);
    check(irq_n, 0, "R8 irq pulse low");
    check(rst_req_n, 1, "R8 reset untouched");
    flag_write(1'b0);
    ctl_irq_en = 0;
    fast_ticks(3);
    check(irq_n, 0, "R8 pulse not truncated");
    check(alarm_flag, 1, "R8 flag held in pulse");
    wr(2'd0, 8'h03);
    fast_ticks(PT - 4);
    check(irq_n, 0, "R8 pulse one tick from end");
    fast_ticks(1);
    check(irq_n, 1, "R8 pulse ended");
    check(alarm_flag, 0, "R8 flag self cleared");
    fast_ticks(2);
    rd(2'd0, rv); check(rv, 1, "R9 decrement deferred to pulse end");
  endtask

  task automatic t_preset_flag();
    ctl_mode = 0; ctl_steer = 0; ctl_irq_en = 0;
    wr(2'd0, 8'h01);
    sec_ticks(1);
    check(alarm_flag, 1, "R11 flag preset");
    ctl_mode = 1; step();
    check(rst_req_n, 0, "R11 pulse starts at once");
    fast_ticks(PT);
    check(rst_req_n, 1, "R11 pulse ends");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_storage();
    t_periodic();
    t_periodic_irq();
    t_zero_seed();
    t_wd_reset();
    t_wd_irq();
    t_preset_flag();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule